// File: doc/BRIEF.md
# Message-Signaled Interrupt Aggregator with Retry

This block gathers completion events from up to sixteen on-chip agents, such as DMA engines and accelerators, and turns them into message-signaled interrupt requests for a PCIe endpoint core. It presents one vector at a time on a request/accept handshake. When several sources are waiting, it picks one by fixed priority. It does not offer the next vector until the endpoint has accepted the current one.

An accepted message can still be lost, because the endpoint may drop it silently when the link is saturated. Endpoint acceptance therefore does not end an interrupt. Each source stays pending until the host writes its acknowledge bit. If that write does not come within a programmable number of cycles after acceptance, the source re-enters arbitration and its vector is sent again. A two-entry register port lets the host read the pending bits, acknowledge sources and set the retry interval.

Top module: `msi_retry_agg`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `msi_req` is low and no source is pending. The retry interval then reads back as `DEF_TMO`, which is 64 by default.
- R2: A rising edge on `src_evt[i]` marks source i pending. Further edges while it is pending merge into the same interrupt, so only one request is made. A level held high after an acknowledge does not mark the source pending again.
- R3: Source i is always sent as vector value i in the 5-bit `msi_vec` field. Among eligible sources, the lowest index is offered first.
- R4: Once `msi_req` is high, it stays high and `msi_vec` stays unchanged until a cycle in which `msi_ack` is high. A newly arriving source cannot replace the vector on offer.
- R5: Endpoint acceptance does not clear a pending source. Reading entry 0 (`reg_sel`=0) returns source i's pending state in bit i.
- R6: A source that has been accepted and is waiting for the host is skipped by arbitration, so lower-priority sources are offered meanwhile.
- R7: Let T be the nonzero retry interval. If a source is accepted at clock edge E and has no host acknowledge, it becomes eligible again at edge E+T. With no other traffic, `msi_req` rises again with the same vector at edge E+T+1. The retried source competes at its normal priority.
- R8: A retry interval of 0 disables retries. An accepted source then waits for the host indefinitely.
- R9: Writing entry 0 acknowledges sources: each 1 bit clears that source's pending state and stops its retries. Bits written as 0 leave their sources unchanged.
- R10: A rising edge that arrives in the same cycle as the acknowledge of its own source keeps the source pending, and the source is offered again.
- R11: Entry 1 (`reg_sel`=1) holds the retry interval and can be written and read. `reg_rdata` returns the selected entry one clock after `reg_sel` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NUM_SRC | Interrupt event inputs, one per source; a rising edge is an event |
| msi_req | output | 1 | Interrupt request to the endpoint |
| msi_vec | output | VEC_W | Vector offered with the request |
| msi_ack | input | 1 | Endpoint accepts the offered vector |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 1 | Entry select: 0 = pending/acknowledge, 1 = retry interval |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Registered read data of the selected entry |

## Verification
The handshake is exercised with:
- single events;
- simultaneous events on two sources, to separate the priority order from arrival order;
- an event that arrives while another vector is held unaccepted, which shows whether the offer stays stable.

The retry path is timed to the exact cycle at the default-free interval of 10. It is also run against competing traffic, to show whether a retried source returns at its normal priority rather than jumping the queue. Repeated edges, a held-high level, an edge that coincides with its own acknowledge, and partial acknowledge masks separate merging behaviour from bit-selective clearing. An interval of 0 is used to confirm that no retries occur.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  typedef enum logic [1:0] {
    SLOT_POOL  = 2'd0,
    SLOT_OFFER = 2'd1,
    SLOT_WAIT  = 2'd2
  } slot_state_e;

  localparam logic SEL_PEND = 1'b0;
  localparam logic SEL_TMO  = 1'b1;
endpackage

// File: rtl/msi_src_slot.sv
module msi_src_slot
  import msi_agg_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             host_clr,
  input  logic             grant,
  input  logic             accept,
  input  logic [TMO_W-1:0] tmo_val,
  output logic             pend,
  output logic             elig
);
  slot_state_e      st;
  logic [TMO_W-1:0] cnt;
  logic             pend_next;

  assign pend_next = rise | (pend & ~host_clr);
  assign elig      = pend && (st == SLOT_POOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      st   <= SLOT_POOL;
      cnt  <= '0;
    end else begin
      pend <= pend_next;
      case (st)
        SLOT_POOL: begin
          if (grant) st <= SLOT_OFFER;
        end
        SLOT_OFFER: begin
          if (accept) begin
            if (pend_next) begin
              st  <= SLOT_WAIT;
              cnt <= tmo_val;
            end else begin
              st <= SLOT_POOL;
            end
          end
        end
        SLOT_WAIT: begin
          if (host_clr) begin
            st <= SLOT_POOL;
          end else if (cnt == TMO_W'(1)) begin
            st <= SLOT_POOL;
          end else if (cnt != '0) begin
            cnt <= cnt - TMO_W'(1);
          end
        end
        default: st <= SLOT_POOL;
      endcase
    end
  end
endmodule

// File: rtl/msi_prio_pick.sv
module msi_prio_pick #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    onehot = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/msi_host_regs.sv
module msi_host_regs
  import msi_agg_pkg::*;
#(
  parameter int          NUM_SRC = 16,
  parameter int          DATA_W  = 32,
  parameter int          TMO_W   = 32,
  parameter logic [TMO_W-1:0] DEF_TMO = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  rdata,
  output logic [TMO_W-1:0]   tmo_val,
  output logic [NUM_SRC-1:0] clr_vec
);
  assign clr_vec = (wr && sel == SEL_PEND) ? wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_val <= DEF_TMO;
      rdata   <= '0;
    end else begin
      if (wr && sel == SEL_TMO) tmo_val <= wdata[TMO_W-1:0];
      rdata <= (sel == SEL_TMO) ? DATA_W'(tmo_val) : DATA_W'(pend);
    end
  end
endmodule

// File: rtl/msi_retry_agg.sv
module msi_retry_agg
  import msi_agg_pkg::*;
#(
  parameter int          NUM_SRC = 16,
  parameter int          VEC_W   = 5,
  parameter int          DATA_W  = 32,
  parameter int          TMO_W   = 32,
  parameter logic [TMO_W-1:0] DEF_TMO = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic               msi_req,
  output logic [VEC_W-1:0]   msi_vec,
  input  logic               msi_ack,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] elig_vec;
  logic [NUM_SRC-1:0] grant_vec;
  logic [NUM_SRC-1:0] acc_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] pick_onehot;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  logic [TMO_W-1:0]   tmo_val;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_evt;
  end
  assign rise_vec = src_evt & ~src_q;

  msi_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req    (elig_vec),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  assign grant_vec = msi_req ? '0 : pick_onehot;

  always_ff @(posedge clk) begin
    if (rst) begin
      msi_req <= 1'b0;
      msi_vec <= '0;
    end else if (msi_req) begin
      if (msi_ack) msi_req <= 1'b0;
    end else if (pick_any) begin
      msi_req <= 1'b1;
      msi_vec <= VEC_W'(pick_idx);
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    assign acc_vec[g] = msi_req && msi_ack && (msi_vec == VEC_W'(g));
    msi_src_slot #(.TMO_W(TMO_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .rise     (rise_vec[g]),
      .host_clr (clr_vec[g]),
      .grant    (grant_vec[g]),
      .accept   (acc_vec[g]),
      .tmo_val  (tmo_val),
      .pend     (pend_vec[g]),
      .elig     (elig_vec[g])
    );
  end

  msi_host_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .TMO_W   (TMO_W),
    .DEF_TMO (DEF_TMO)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .pend    (pend_vec),
    .rdata   (reg_rdata),
    .tmo_val (tmo_val),
    .clr_vec (clr_vec)
  );
endmodule

// File: rtl/msi_retry_agg_chk.sv
module msi_retry_agg_chk #(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 5,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_evt,
  input logic               msi_req,
  input logic [VEC_W-1:0]   msi_vec,
  input logic               msi_ack,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] elig_vec
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] elig_q;
  logic [NUM_SRC-1:0] edge_now;
  logic [NUM_SRC-1:0] low_mask;
  logic [IDX_W-1:0]   vec_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      elig_q <= '0;
    end else begin
      src_q  <= src_evt;
      elig_q <= elig_vec;
    end
  end

  assign edge_now = src_evt & ~src_q;
  assign vec_idx  = msi_vec[IDX_W-1:0];
  assign low_mask = (NUM_SRC'(1) << vec_idx) - NUM_SRC'(1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!msi_req && pend_vec == '0));

  // R2
  edge_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_now != '0) |=> ((pend_vec & $past(edge_now)) == $past(edge_now)));

  // R3
  vec_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> (msi_vec < VEC_W'(NUM_SRC)));

  // R3
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!msi_req && elig_vec != '0) |=>
      (msi_req && elig_q[vec_idx] && ((elig_q & low_mask) == '0)));

  // R4
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msi_req && !msi_ack) |=> (msi_req && $stable(msi_vec)));

  // R5
  accept_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (msi_req && msi_ack && pend_vec[vec_idx] &&
     !(reg_wr && !reg_sel && reg_wdata[vec_idx])) |=> pend_vec[$past(vec_idx)]);

  // R9
  host_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel) |=>
      ((pend_vec & $past(reg_wdata[NUM_SRC-1:0] & ~edge_now)) == '0));
endmodule

bind msi_retry_agg msi_retry_agg_chk #(
  .NUM_SRC (NUM_SRC),
  .VEC_W   (VEC_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_evt   (src_evt),
  .msi_req   (msi_req),
  .msi_vec   (msi_vec),
  .msi_ack   (msi_ack),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .pend_vec  (pend_vec),
  .elig_vec  (elig_vec)
);

// File: tb/msi_retry_agg_test.sv
module msi_retry_agg_test;
  localparam int NS   = 16;
  localparam int VW   = 5;
  localparam int DW   = 32;
  localparam int DEFT = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_evt = '0;
  logic          msi_req;
  logic [VW-1:0] msi_vec;
  logic          msi_ack = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  msi_retry_agg uut (
    .clk(clk), .rst(rst), .src_evt(src_evt),
    .msi_req(msi_req), .msi_vec(msi_vec), .msi_ack(msi_ack),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk) src_evt = src_evt | m;
    @(negedge clk) src_evt = src_evt & ~m;
  endtask

  task automatic reg_write(input logic s, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic s, output logic [DW-1:0] d);
    @(negedge clk) reg_sel = s;
    @(negedge clk) d = reg_rdata;
  endtask

  task automatic accept();
    @(negedge clk) msi_ack = 1'b1;
    @(negedge clk) msi_ack = 1'b0;
  endtask

  task automatic wait_req(input string tag, input int exp_vec);
    int n = 0;
    while (!msi_req && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(msi_req === 1'b1 && msi_vec == VW'(exp_vec), tag,
        {26'd0, msi_req, msi_vec}, {26'd0, 1'b1, 5'(exp_vec)});
  endtask

  task automatic quiet(input string tag, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msi_req) seen = 1;
    end
    chk(!seen, tag, 32'(seen), 32'd0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk(msi_req === 1'b0, "R1 request low after reset", 32'(msi_req), 32'd0);
    reg_read(1'b0, d);
    chk(d == 0, "R1 pending clear after reset", d, 32'd0);
    reg_read(1'b1, d);
    chk(d == DEFT, "R1 R11 default interval", d, DEFT);
    reg_write(1'b1, 32'd20);
    reg_read(1'b1, d);
    chk(d == 20, "R11 interval write/read", d, 32'd20);
  endtask

  task automatic t_single();
    logic [DW-1:0] d;
    pulse(NS'(1) << 3);
    wait_req("R2 R3 single event vector 3", 3);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(msi_req && msi_vec == 3, "R4 held until accept", {27'd0, msi_vec}, 32'd3);
    accept();
    reg_read(1'b0, d);
    chk(d == 32'h8, "R5 pending kept after accept", d, 32'h8);
    reg_write(1'b0, 32'h8);
    reg_read(1'b0, d);
    chk(d == 0, "R9 acknowledge clears", d, 32'd0);
    quiet("R9 no retry after acknowledge", 30);
  endtask

  task automatic t_priority();
    pulse((NS'(1) << 5) | (NS'(1) << 2));
    wait_req("R3 lowest index first", 2);
    accept();
    wait_req("R6 waiting source skipped", 5);
    accept();
    reg_write(1'b0, 32'h24);
    quiet("R9 both acknowledged", 30);
  endtask

  task automatic t_retry_time();
    reg_write(1'b1, 32'd10);
    pulse(NS'(1) << 7);
    wait_req("R3 vector 7", 7);
    accept();
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk(msi_req === 1'b0, "R7 no retry before interval", 32'(msi_req), 32'd0);
    @(negedge clk);
    chk(msi_req === 1'b1 && msi_vec == 7, "R7 retry at interval+1",
        {26'd0, msi_req, msi_vec}, {26'd0, 1'b1, 5'd7});
    accept();
    reg_write(1'b0, 32'h80);
    quiet("R7 retries end on acknowledge", 30);
  endtask

  task automatic t_retry_prio();
    pulse(NS'(1) << 9);
    wait_req("R3 vector 9", 9);
    accept();
    pulse(NS'(1) << 12);
    wait_req("R6 vector 12 while 9 waits", 12);
    for (int i = 0; i < 15; i++) @(negedge clk);
    pulse(NS'(1) << 4);
    chk(msi_req && msi_vec == 12, "R4 offer not replaced", {27'd0, msi_vec}, 32'd12);
    accept();
    reg_write(1'b0, 32'h1000);
    wait_req("R7 retried source at normal priority", 4);
    accept();
    reg_write(1'b0, 32'h10);
    wait_req("R7 retried vector 9", 9);
    accept();
    reg_write(1'b0, 32'h200);
    quiet("R7 contested retries end", 30);
  endtask

  task automatic t_no_retry();
    logic [DW-1:0] d;
    reg_write(1'b1, 32'd0);
    pulse(NS'(1) << 6);
    wait_req("R3 vector 6", 6);
    accept();
    quiet("R8 interval zero disables retry", 100);
    reg_read(1'b0, d);
    chk(d == 32'h40, "R8 still pending", d, 32'h40);
    reg_write(1'b0, 32'h40);
  endtask

  task automatic t_merge();
    logic [DW-1:0] d;
    pulse(NS'(1) << 8);
    wait_req("R2 vector 8", 8);
    pulse(NS'(1) << 8);
    accept();
    pulse(NS'(1) << 8);
    quiet("R2 repeated edges merged", 20);
    reg_write(1'b0, 32'h100);
    reg_read(1'b0, d);
    chk(d == 0, "R2 merged cleared once", d, 32'd0);
    @(negedge clk) src_evt[8] = 1'b1;
    wait_req("R2 level edge", 8);
    accept();
    reg_write(1'b0, 32'h100);
    quiet("R2 held level no re-arm", 10);
    reg_read(1'b0, d);
    chk(d == 0, "R2 held level pending clear", d, 32'd0);
    @(negedge clk) src_evt[8] = 1'b0;
  endtask

  task automatic t_edge_vs_clear();
    logic [DW-1:0] d;
    pulse(NS'(1) << 10);
    wait_req("R3 vector 10", 10);
    accept();
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h400; src_evt[10] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; src_evt[10] = 1'b0;
    reg_read(1'b0, d);
    chk(d == 32'h400, "R10 edge beats clear", d, 32'h400);
    wait_req("R10 re-offered", 10);
    accept();
    reg_write(1'b0, 32'h400);
  endtask

  task automatic t_partial_clear();
    logic [DW-1:0] d;
    pulse((NS'(1) << 3) | (NS'(1) << 11));
    wait_req("R3 vector 3 first", 3);
    accept();
    wait_req("R6 vector 11 next", 11);
    accept();
    reg_write(1'b0, 32'h8);
    reg_read(1'b0, d);
    chk(d == 32'h800, "R9 zero bits untouched", d, 32'h800);
    reg_write(1'b0, 32'h800);
    reg_read(1'b0, d);
    chk(d == 0, "R9 final clear", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_priority();
    t_retry_time();
    t_retry_prio();
    t_no_retry();
    t_merge();
    t_edge_vs_clear();
    t_partial_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule